// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical 4-bit slices. All state bits of all slices change together on the rising clock edge. A parallel preset input loads any starting value. A clear input zeroes the count, and a build-time parameter chooses whether clear acts at once or at the next edge. Counting needs two enables. The shared count enable goes to every slice. The chain enable goes only to the lowest slice, and each slice's carry drives the chain enable of the slice above it, so a wide counter needs no extra gating.

An optional modulus parameter shortens the count cycle. When it is non-zero, the counter returns to zero on the edge after it reaches the modulus minus one while counting. The carry output then flags that terminal value in place of the all-ones value. The block is used as a divider, a timebase or a preset down-count replacement. The slices are assembled behind one port list.

Top module: `casc_counter`

## Requirements
- R1: With `rst` high at a rising edge, `value` becomes 0 after that edge. `rst` takes priority over every other input.
- R2: With `clear_n` and `preset_n` high, `value` increments by one at each edge where `cnt_en` and `chain_en` are both high. It wraps from all-ones (or from the terminal value, see R9) to 0. If either enable is low, `value` holds.
- R3: A low `preset_n` copies `data_in` into `value` at the next edge, whatever the enable levels. Slice k takes bits [4k+3:4k].
- R4: With the synchronous clear build (ASYNC_CLR=0), a low `clear_n` makes `value` 0 at the next edge, and not before it. This holds whatever the enable levels, and also when `preset_n` is low at the same time.
- R5: With the asynchronous clear build (ASYNC_CLR=1), a low `clear_n` makes `value` 0 at once, with no clock edge. It stays 0 while `clear_n` is low, even when `preset_n` is low.
- R6: `carry_out` is high exactly when `chain_en` is high and `value` is at the terminal value. Without a modulus the terminal value is all ones. `cnt_en` has no effect on `carry_out`. This output is combinational.
- R7: Carry passes between slices within one cycle. In a two-slice build, 0x0F counts to 0x10 in a single edge.
- R8: On a single-slice build the sequence works as follows. A clear gives 0, a preset of 12 gives 12, and six counting edges give 13, 14, 15, 0, 1 and 2. With both enables low the value then stays at 2.
- R9: With MOD_LIMIT=M non-zero, a counter at M-1 goes to 0 on the next counting edge. At M-1 with `chain_en` high, `carry_out` is high. At M-1 with `cnt_en` low, the value holds.
- R10: A change on `preset_n`, `cnt_en` or `chain_en` between edges leaves `value` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_n | input | 1 | Active-low clear (synchronous or asynchronous by parameter) |
| preset_n | input | 1 | Active-low parallel load |
| cnt_en | input | 1 | Count enable shared by all slices |
| chain_en | input | 1 | Count enable for the lowest slice; also gates carry_out |
| data_in | input | STAGE_W*NUM_STAGES | Preset value |
| value | output | STAGE_W*NUM_STAGES | Current count |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
The bench builds three copies and drives them with the same stimulus. The first is a two-slice synchronous-clear counter with no modulus, which brings carry between slices and the 8-bit wrap within reach. The second is a one-slice asynchronous-clear counter, which exposes clear between edges and the 4-bit reference sequence. The third is a one-slice synchronous counter with MOD_LIMIT=10, which shows the shortened cycle, its terminal carry, and preset values above the terminal value that count on through 15.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;

    // Per-edge operation chosen by a slice, highest priority first in pick_op
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_COUNT,
        OP_WRAP,
        OP_LOAD,
        OP_CLEAR
    } stage_op_e;

    // Control shared by all slices of one counter
    typedef struct packed {
        logic load;   // preset requested
        logic cnt;    // shared count enable
        logic wrap;   // modulus terminal reached while counting
    } stage_ctl_t;

    function automatic stage_op_e pick_op(input logic clr, input stage_ctl_t c,
                                          input logic t_in);
        if (clr)            return OP_CLEAR;
        if (c.load)         return OP_LOAD;
        if (c.wrap)         return OP_WRAP;
        if (c.cnt && t_in)  return OP_COUNT;
        return OP_HOLD;
    endfunction

    // Terminal value: modulus minus one, or all ones when no modulus is set
    function automatic logic [31:0] term_of(input int unsigned w, input int unsigned m);
        if (m != 0)
            return 32'(m - 1);
        if (w >= 32)
            return '1;
        return (32'd1 << w) - 32'd1;
    endfunction

endpackage

// File: rtl/ctr_term_detect.sv
`timescale 1ns/1ps
module ctr_term_detect
    import ctr_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter int unsigned MOD_LIMIT = 0
) (
    input  logic [W-1:0] q,
    output logic         at_term
);
    localparam logic [W-1:0] TERM = W'(term_of(W, MOD_LIMIT));

    assign at_term = (q == TERM);
endmodule

// File: rtl/ctr_ctl_decode.sv
`timescale 1ns/1ps
module ctr_ctl_decode
    import ctr_pkg::*;
#(
    parameter int unsigned MOD_LIMIT = 0
) (
    input  logic       preset_n,
    input  logic       cnt_en,
    input  logic       chain_en,
    input  logic       at_term,
    output stage_ctl_t ctl
);
    localparam bit HAS_MOD = (MOD_LIMIT != 0);

    always_comb begin
        ctl.load = ~preset_n;
        ctl.cnt  = cnt_en;
        ctl.wrap = HAS_MOD && at_term && cnt_en && chain_en;
    end
endmodule

// File: rtl/ctr_stage.sv
`timescale 1ns/1ps
module ctr_stage
    import ctr_pkg::*;
#(
    parameter int unsigned SW        = 4,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_n,
    input  stage_ctl_t    ctl,
    input  logic          t_in,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q,
    output logic          rc
);
    logic          sync_clr;
    stage_op_e     op;
    logic [SW-1:0] nxt;

    // In the asynchronous build clear acts through the flop's reset path
    assign sync_clr = ASYNC_CLR ? 1'b0 : ~clear_n;
    assign op       = pick_op(sync_clr, ctl, t_in);

    always_comb begin
        unique case (op)
            OP_CLEAR, OP_WRAP: nxt = '0;
            OP_LOAD:           nxt = d;
            OP_COUNT:          nxt = q + SW'(1);
            default:           nxt = q;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_aclr
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n)  q <= '0;
                else if (rst)  q <= '0;
                else           q <= nxt;
            end
        end else begin : g_sclr
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= nxt;
            end
        end
    endgenerate

    // Lookahead carry: combinational from state and chain enable
    assign rc = t_in & (&q);
endmodule

// File: rtl/casc_counter.sv
`timescale 1ns/1ps
module casc_counter
    import ctr_pkg::*;
#(
    parameter int unsigned STAGE_W    = 4,
    parameter int unsigned NUM_STAGES = 2,
    parameter bit          ASYNC_CLR  = 1'b0,
    parameter int unsigned MOD_LIMIT  = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear_n,
    input  logic                          preset_n,
    input  logic                          cnt_en,
    input  logic                          chain_en,
    input  logic [STAGE_W*NUM_STAGES-1:0] data_in,
    output logic [STAGE_W*NUM_STAGES-1:0] value,
    output logic                          carry_out
);
    localparam int unsigned CW = STAGE_W * NUM_STAGES;

    logic              at_term;
    stage_ctl_t        ctl;
    logic [NUM_STAGES:0] t_chain;

    ctr_term_detect #(.W(CW), .MOD_LIMIT(MOD_LIMIT)) u_term (
        .q       (value),
        .at_term (at_term)
    );

    ctr_ctl_decode #(.MOD_LIMIT(MOD_LIMIT)) u_ctl (
        .preset_n (preset_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .at_term  (at_term),
        .ctl      (ctl)
    );

    assign t_chain[0] = chain_en;

    generate
        for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
            ctr_stage #(.SW(STAGE_W), .ASYNC_CLR(ASYNC_CLR)) u_stage (
                .clk     (clk),
                .rst     (rst),
                .clear_n (clear_n),
                .ctl     (ctl),
                .t_in    (t_chain[k]),
                .d       (data_in[k*STAGE_W +: STAGE_W]),
                .q       (value[k*STAGE_W +: STAGE_W]),
                .rc      (t_chain[k+1])
            );
        end
    endgenerate

    assign carry_out = (MOD_LIMIT == 0) ? t_chain[NUM_STAGES] : (chain_en & at_term);
endmodule

// File: rtl/casc_counter_chk.sv
`timescale 1ns/1ps
module casc_counter_chk
    import ctr_pkg::*;
#(
    parameter int unsigned STAGE_W    = 4,
    parameter int unsigned NUM_STAGES = 2,
    parameter bit          ASYNC_CLR  = 1'b0,
    parameter int unsigned MOD_LIMIT  = 0
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          clear_n,
    input logic                          preset_n,
    input logic                          cnt_en,
    input logic                          chain_en,
    input logic [STAGE_W*NUM_STAGES-1:0] data_in,
    input logic [STAGE_W*NUM_STAGES-1:0] value,
    input logic                          carry_out
);
    localparam int unsigned    CW   = STAGE_W * NUM_STAGES;
    localparam logic [CW-1:0]  TERM = CW'(term_of(CW, MOD_LIMIT));
    localparam bit             SYNC = (ASYNC_CLR == 1'b0);

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> value == '0);

    // R2
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (SYNC && clear_n && preset_n && cnt_en && chain_en) |=>
        value == (($past(value) == TERM) ? '0 : $past(value) + CW'(1)));

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (SYNC && clear_n && preset_n && !(cnt_en && chain_en)) |=> $stable(value));

    // R3
    a_r3_preset: assert property (@(posedge clk) disable iff (rst)
        (SYNC && clear_n && !preset_n) |=> value == $past(data_in));

    // R4
    a_r4_sync_clear: assert property (@(posedge clk) disable iff (rst)
        (SYNC && !clear_n) |=> value == '0);

    // R5
    a_r5_async_clear: assert property (@(posedge clk) disable iff (rst)
        (!SYNC && !clear_n) |-> value == '0);

    // R6
    a_r6_carry_gated: assert property (@(posedge clk) disable iff (rst)
        !chain_en |-> !carry_out);

    // R6
    a_r6_carry_term: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> value == TERM);
endmodule

bind casc_counter casc_counter_chk #(
    .STAGE_W    (STAGE_W),
    .NUM_STAGES (NUM_STAGES),
    .ASYNC_CLR  (ASYNC_CLR),
    .MOD_LIMIT  (MOD_LIMIT)
) u_chk (.*);

// File: tb/casc_counter_tb_top.sv
`timescale 1ns/1ps
module casc_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear_n = 1'b1;
    logic       clear_a_n = 1'b1;
    logic       preset_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       chain_en = 1'b0;
    logic [7:0] data = 8'h00;

    logic [7:0] v_main;
    logic       c_main;
    logic [3:0] v_a;
    logic       c_a;
    logic [3:0] v_m;
    logic       c_m;

    int  checks = 0;
    int  fails  = 0;
    bit  started = 1'b0;
    bit  done    = 1'b0;
    string cur_tag = "R1";

    logic [7:0] m_main = 8'h00;
    logic [3:0] m_a    = 4'h0;
    logic [3:0] m_m    = 4'h0;

    always #2 clk = ~clk;

    casc_counter #(.STAGE_W(4), .NUM_STAGES(2), .ASYNC_CLR(1'b0), .MOD_LIMIT(0)) dut_i (
        .clk(clk), .rst(rst), .clear_n(clear_n), .preset_n(preset_n),
        .cnt_en(cnt_en), .chain_en(chain_en), .data_in(data),
        .value(v_main), .carry_out(c_main));

    casc_counter #(.STAGE_W(4), .NUM_STAGES(1), .ASYNC_CLR(1'b1), .MOD_LIMIT(0)) dut_a_i (
        .clk(clk), .rst(rst), .clear_n(clear_a_n), .preset_n(preset_n),
        .cnt_en(cnt_en), .chain_en(chain_en), .data_in(data[3:0]),
        .value(v_a), .carry_out(c_a));

    casc_counter #(.STAGE_W(4), .NUM_STAGES(1), .ASYNC_CLR(1'b0), .MOD_LIMIT(10)) dut_m_i (
        .clk(clk), .rst(rst), .clear_n(clear_n), .preset_n(preset_n),
        .cnt_en(cnt_en), .chain_en(chain_en), .data_in(data[3:0]),
        .value(v_m), .carry_out(c_m));

    // Behavioural reference models
    always @(posedge clk) begin
        if (rst)                    m_main = 8'h00;
        else if (!clear_n)          m_main = 8'h00;
        else if (!preset_n)         m_main = data;
        else if (cnt_en && chain_en) m_main = m_main + 8'd1;

        if (!clear_a_n)             m_a = 4'h0;
        else if (rst)               m_a = 4'h0;
        else if (!preset_n)         m_a = data[3:0];
        else if (cnt_en && chain_en) m_a = m_a + 4'd1;

        if (rst)                    m_m = 4'h0;
        else if (!clear_n)          m_m = 4'h0;
        else if (!preset_n)         m_m = data[3:0];
        else if (cnt_en && chain_en) m_m = (m_m == 4'd9) ? 4'd0 : m_m + 4'd1;
    end

    always @(negedge clear_a_n) m_a = 4'h0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk({cur_tag, " model main value"}, 32'(v_main), 32'(m_main));
            chk({cur_tag, " model main carry"}, 32'(c_main), 32'(chain_en && m_main == 8'hFF));
            chk({cur_tag, " model async value"}, 32'(v_a), 32'(m_a));
            chk({cur_tag, " model async carry"}, 32'(c_a), 32'(chain_en && m_a == 4'hF));
            chk({cur_tag, " model mod value"}, 32'(v_m), 32'(m_m));
            chk({cur_tag, " model mod carry"}, 32'(c_m), 32'(chain_en && m_m == 4'd9));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run hung actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] seq_exp [6];
        seq_exp = '{4'd13, 4'd14, 4'd15, 4'd0, 4'd1, 4'd2};

        tick();
        started = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        chk("R1 reset main", 32'(v_main), 0);
        chk("R1 reset async", 32'(v_a), 0);
        chk("R1 reset carry", 32'(c_main), 0);

        // R8 reference sequence
        cur_tag = "R8";
        clear_n = 1'b0; clear_a_n = 1'b0;
        tick();
        clear_n = 1'b1; clear_a_n = 1'b1;
        preset_n = 1'b0; data = 8'h0C;
        tick();
        chk("R8 preset twelve", 32'(v_a), 12);
        preset_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R8 count step", 32'(v_a), 32'(seq_exp[i]));
        end
        cnt_en = 1'b0; chain_en = 1'b0;
        tick();
        tick();
        chk("R8 inhibit hold", 32'(v_a), 2);

        // R2 one enable low holds
        cur_tag = "R2";
        cnt_en = 1'b1; chain_en = 1'b0;
        tick(); tick();
        chk("R2 hold chain_en low", 32'(v_main), 8'h12);
        cnt_en = 1'b0; chain_en = 1'b1;
        tick(); tick();
        chk("R2 hold cnt_en low", 32'(v_main), 8'h12);
        chain_en = 1'b0;

        // R6 carry with cnt_en low
        cur_tag = "R6";
        preset_n = 1'b0; data = 8'hFF;
        tick();
        preset_n = 1'b1; chain_en = 1'b1; cnt_en = 1'b0;
        #0.2;
        chk("R6 carry main at all ones", 32'(c_main), 1);
        chk("R6 carry async at all ones", 32'(c_a), 1);
        chk("R6 carry mod not terminal", 32'(c_m), 0);
        chain_en = 1'b0;
        #0.2;
        chk("R6 carry gated by chain_en", 32'(c_a), 0);

        // R2 wrap to zero
        cur_tag = "R2";
        cnt_en = 1'b1; chain_en = 1'b1;
        tick();
        chk("R2 wrap main", 32'(v_main), 0);
        chk("R2 wrap async", 32'(v_a), 0);
        cnt_en = 1'b0; chain_en = 1'b0;

        // R7 carry between slices
        cur_tag = "R7";
        preset_n = 1'b0; data = 8'h0F;
        tick();
        preset_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
        tick();
        chk("R7 cascade step", 32'(v_main), 8'h10);

        // R3 preset overrides enables
        cur_tag = "R3";
        preset_n = 1'b0; data = 8'hA5;
        tick();
        chk("R3 preset main", 32'(v_main), 8'hA5);
        chk("R3 preset slice", 32'(v_a), 4'h5);
        preset_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;

        // R10 control changes wait for the edge
        cur_tag = "R10";
        tick();
        preset_n = 1'b0; data = 8'h3C;
        #0.5;
        chk("R10 preset waits for edge", 32'(v_main), 8'hA5);
        tick();
        chk("R10 preset at edge", 32'(v_main), 8'h3C);
        preset_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
        #0.5;
        chk("R10 enable waits for edge", 32'(v_main), 8'h3C);
        tick();
        chk("R10 count at edge", 32'(v_main), 8'h3D);

        // R4 synchronous clear beats preset
        cur_tag = "R4";
        clear_n = 1'b0; preset_n = 1'b0; data = 8'h77;
        #0.5;
        chk("R4 no clear before edge", 32'(v_main), 8'h3D);
        tick();
        chk("R4 clear beats preset main", 32'(v_main), 0);
        chk("R4 clear beats preset mod", 32'(v_m), 0);
        clear_n = 1'b1; preset_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;

        // R5 asynchronous clear
        cur_tag = "R5";
        preset_n = 1'b0; data = 8'h0B;
        tick();
        chk("R5 preset before clear", 32'(v_a), 4'hB);
        preset_n = 1'b1;
        tick();
        clear_a_n = 1'b0;
        #0.5;
        chk("R5 immediate clear", 32'(v_a), 0);
        preset_n = 1'b0;
        tick();
        chk("R5 clear held over preset", 32'(v_a), 0);
        clear_a_n = 1'b1; preset_n = 1'b1;

        // R9 modulus ten
        cur_tag = "R9";
        clear_n = 1'b0;
        tick();
        clear_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
        for (int i = 1; i <= 9; i++) tick();
        chk("R9 reach terminal", 32'(v_m), 9);
        chk("R9 terminal carry", 32'(c_m), 1);
        cnt_en = 1'b0;
        tick();
        chk("R9 hold at terminal", 32'(v_m), 9);
        cnt_en = 1'b1;
        tick();
        chk("R9 wrap to zero", 32'(v_m), 0);
        tick();
        chk("R9 restart count", 32'(v_m), 1);

        // R1 reset in mid run
        cur_tag = "R1";
        rst = 1'b1;
        tick();
        chk("R1 mid-run reset main", 32'(v_main), 0);
        chk("R1 mid-run reset mod", 32'(v_m), 0);
        rst = 1'b0; cnt_en = 1'b0; chain_en = 1'b0;
        tick();
        tick();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule